// File: doc/BRIEF.md
# Audio DAC Sample-Rate Strobe Generator and Stereo Sample FIFO

This block feeds a stereo sigma-delta modulator. Software picks a playback rate with a small code. The block then takes one of two master-clock enables: one family serves the multiples of 48 kHz and the other the multiples of 44.1 kHz. It divides the chosen enable down to an oversampling strobe at OSR times the sample rate, with OSR defaulting to 256. It also produces a strobe once per sample period.

A processor writes PCM words through a simple write port, always a left word followed by a right word. A word pair waits in a FIFO of four stereo slots (eight 20-bit words). On every sample strobe the block removes one pair and presents it to the modulator with a one-cycle valid pulse. If no pair is waiting, the last pair is held and a sticky underrun flag is set. The FIFO fill level is reported in words. A service request stays high while two or more pair slots are free.

Both master clocks are modelled as clock enables inside one clock domain. The enable `mclkEnA` stands for the 24.576 MHz family and `mclkEnB` for the 22.5792 MHz family. Either master clock is 512 times the top rate of its family, so it is divided by 2, 3, 4, 6, 8 or 12 to reach the oversampling rate.

Top module: `dac_rate_fifo`

## Requirements
- R1: Rate codes map to the following family and divisor, where the oversampling strobe `osStb` pulses once every divisor-th enable of the chosen family: 0=48k (A, 2), 1=44.1k (B, 2), 2=32k (A, 3), 3=24k (A, 4), 4=22.05k (B, 4), 5=16k (A, 6), 6=12k (A, 8), 7=11.025k (B, 8), 8=8k (A, 12).
- R2: `sampleStb` pulses on every OSR-th `osStb` pulse and only in a cycle where `osStb` is also high. A sample period therefore spans divisor × OSR enables of the chosen family.
- R3: Codes 9 to 15 produce no `osStb` and no `sampleStb`. Any change of the code restarts the divider, so with `mclkEnA` held high a family-A code gives its first `sampleStb` divisor × OSR + 1 cycles after the code changes.
- R4: Written words alternate, starting with left. A right write completes a pair and enqueues it. `fifoLevel` = 2 × stored pairs + 1 while a left word waits for its partner.
- R5: A sample strobe that finds a stored pair dequeues the oldest one. `pcmLeft`/`pcmRight` take that pair, and `pcmStb` pulses, in the cycle after `sampleStb`. The outputs keep their old values during the `sampleStb` cycle.
- R6: A sample strobe with no stored pair leaves `pcmLeft`/`pcmRight` unchanged, still pulses `pcmStb`, and sets `underrunFlag`, which stays set until reset.
- R7: A left write while four pairs are stored is dropped. It does not change the level or the left/right order, and it sets `overflowFlag`, which stays set until reset.
- R8: `svcReq` is high exactly when at least two of the four pair slots are free, i.e. when `fifoLevel` ≤ 5.
- R9: After reset, `fifoLevel` is 0, both flags are 0, `svcReq` is 1, and `pcmLeft`, `pcmRight`, `pcmStb`, `osStb` and `sampleStb` are 0.
- R10: Pairs leave the FIFO in the order they were written, with each word keeping its channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| mclkEnA | input | 1 | Enable standing for the 48 kHz-family master clock |
| mclkEnB | input | 1 | Enable standing for the 44.1 kHz-family master clock |
| rateCode | input | 4 | Sample-rate select, 0 to 8 valid |
| wrEn | input | 1 | Write strobe for one PCM word |
| wrData | input | 20 | PCM word, left and right alternating |
| osStb | output | 1 | Oversampling strobe (OSR × FS) |
| sampleStb | output | 1 | One pulse per sample period |
| pcmStb | output | 1 | New output pair presented |
| pcmLeft | output | 20 | Left sample to the modulator |
| pcmRight | output | 20 | Right sample to the modulator |
| fifoLevel | output | 4 | Stored words, 0 to 8 |
| svcReq | output | 1 | At least two pair slots free |
| underrunFlag | output | 1 | Sticky: a sample found the FIFO empty |
| overflowFlag | output | 1 | Sticky: a write hit a full FIFO |

## Verification
The level, both flags and the service request come from registers. They are due on the first falling edge after the write or sample strobe that changes them, so the bench reads them half a cycle after each rising edge. The output pair and `pcmStb` trail `sampleStb` by exactly one cycle. The bench's model therefore dequeues on the `sampleStb` it sees and checks the values at the next falling edge. Strobe timing is checked by counting whole cycles between falling edges: from a code change to the first `sampleStb` (divisor × OSR + 1), and between consecutive `sampleStb` pulses. For the family-B enable, which toggles every cycle, each of these counts is doubled.

// File: rtl/dac_rate_fifo_pkg.sv
package dac_rate_fifo_pkg;

  localparam int RATE_CODE_W = 4;
  localparam int DIV_W       = 4;

  typedef struct packed {
    logic             valid;
    logic             famB;
    logic [DIV_W-1:0] div;
  } rateSel_t;

  typedef struct packed {
    logic stageLeft;
    logic pushPair;
    logic popPair;
  } fifoCtl_t;

  function automatic rateSel_t lookupRate(input logic [RATE_CODE_W-1:0] code);
    rateSel_t s;
    s = '{valid: 1'b1, famB: 1'b0, div: 4'd2};
    case (code)
      4'd0:    s = '{valid: 1'b1, famB: 1'b0, div: 4'd2};
      4'd1:    s = '{valid: 1'b1, famB: 1'b1, div: 4'd2};
      4'd2:    s = '{valid: 1'b1, famB: 1'b0, div: 4'd3};
      4'd3:    s = '{valid: 1'b1, famB: 1'b0, div: 4'd4};
      4'd4:    s = '{valid: 1'b1, famB: 1'b1, div: 4'd4};
      4'd5:    s = '{valid: 1'b1, famB: 1'b0, div: 4'd6};
      4'd6:    s = '{valid: 1'b1, famB: 1'b0, div: 4'd8};
      4'd7:    s = '{valid: 1'b1, famB: 1'b1, div: 4'd8};
      4'd8:    s = '{valid: 1'b1, famB: 1'b0, div: 4'd12};
      default: s = '{valid: 1'b0, famB: 1'b0, div: 4'd1};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dac_rate_gen.sv
module dac_rate_gen
  import dac_rate_fifo_pkg::*;
#(
  parameter int OSR = 256
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   mclkEnA,
  input  logic                   mclkEnB,
  input  logic [RATE_CODE_W-1:0] rateCode,
  output logic                   osStb,
  output logic                   sampleStb
);

  localparam int OS_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OSR - 1);

  rateSel_t               sel;
  logic [RATE_CODE_W-1:0] prevCode;
  logic [DIV_W-1:0]       divCnt;
  logic [OS_W-1:0]        osCnt;
  logic                   tickEn;
  logic                   divWrap;
  logic                   osWrap;
  logic                   restart;

  always_comb begin
    sel     = lookupRate(rateCode);
    tickEn  = sel.valid && (sel.famB ? mclkEnB : mclkEnA);
    divWrap = (divCnt == sel.div - 4'd1);
    osWrap  = (osCnt == OS_LAST);
    restart = (rateCode != prevCode) || !sel.valid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCode  <= '0;
      divCnt    <= '0;
      osCnt     <= '0;
      osStb     <= 1'b0;
      sampleStb <= 1'b0;
    end else begin
      prevCode  <= rateCode;
      osStb     <= 1'b0;
      sampleStb <= 1'b0;
      if (restart) begin
        divCnt <= '0;
        osCnt  <= '0;
      end else if (tickEn) begin
        if (divWrap) begin
          divCnt <= '0;
          osStb  <= 1'b1;
          if (osWrap) begin
            osCnt     <= '0;
            sampleStb <= 1'b1;
          end else begin
            osCnt <= osCnt + 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dac_fifo_ctrl.sv
module dac_fifo_ctrl
  import dac_rate_fifo_pkg::*;
#(
  parameter int PAIR_DEPTH = 4,
  localparam int PTR_W = (PAIR_DEPTH > 1) ? $clog2(PAIR_DEPTH) : 1,
  localparam int CNT_W = $clog2(PAIR_DEPTH + 1),
  localparam int LVL_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             sampleStb,
  output fifoCtl_t         ctl,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [LVL_W-1:0] fifoLevel,
  output logic             svcReq,
  output logic             underrunFlag,
  output logic             overflowFlag
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(PAIR_DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAIR_DEPTH);
  localparam logic [CNT_W-1:0] CNT_REQ  = CNT_W'(PAIR_DEPTH - 2);

  logic [CNT_W-1:0] pairCnt;
  logic             wrSide;
  logic             fifoFull;
  logic             fifoEmpty;
  logic             wrLeft;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    fifoFull      = (pairCnt == CNT_FULL);
    fifoEmpty     = (pairCnt == '0);
    wrLeft        = wrEn && !wrSide;
    ctl.stageLeft = wrLeft && !fifoFull;
    ctl.pushPair  = wrEn && wrSide;
    ctl.popPair   = sampleStb && !fifoEmpty;
    fifoLevel     = {pairCnt, wrSide};
    svcReq        = (pairCnt <= CNT_REQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairCnt      <= '0;
      wrSide       <= 1'b0;
      wrPtr        <= '0;
      rdPtr        <= '0;
      underrunFlag <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      if (ctl.stageLeft) wrSide <= 1'b1;
      if (ctl.pushPair) begin
        wrSide <= 1'b0;
        wrPtr  <= bumpPtr(wrPtr);
      end
      if (ctl.popPair) rdPtr <= bumpPtr(rdPtr);
      case ({ctl.pushPair, ctl.popPair})
        2'b10:   pairCnt <= pairCnt + 1'b1;
        2'b01:   pairCnt <= pairCnt - 1'b1;
        default: pairCnt <= pairCnt;
      endcase
      if (wrLeft && fifoFull)     overflowFlag <= 1'b1;
      if (sampleStb && fifoEmpty) underrunFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/dac_fifo_data.sv
module dac_fifo_data
  import dac_rate_fifo_pkg::*;
#(
  parameter int DATA_W     = 20,
  parameter int PAIR_DEPTH = 4,
  localparam int PTR_W = (PAIR_DEPTH > 1) ? $clog2(PAIR_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtl_t          ctl,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sampleStb,
  output logic              pcmStb,
  output logic [DATA_W-1:0] pcmLeft,
  output logic [DATA_W-1:0] pcmRight
);

  logic [DATA_W-1:0] pendLeft;
  logic [DATA_W-1:0] memLeft  [PAIR_DEPTH];
  logic [DATA_W-1:0] memRight [PAIR_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) pendLeft <= '0;
    else if (ctl.stageLeft) pendLeft <= wrData;
  end

  for (genvar g = 0; g < PAIR_DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (ctl.pushPair && wrPtr == PTR_W'(g)) begin
        memLeft[g]  <= pendLeft;
        memRight[g] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcmStb   <= 1'b0;
      pcmLeft  <= '0;
      pcmRight <= '0;
    end else begin
      pcmStb <= sampleStb;
      if (ctl.popPair) begin
        pcmLeft  <= memLeft[rdPtr];
        pcmRight <= memRight[rdPtr];
      end
    end
  end

endmodule

// File: rtl/dac_rate_fifo.sv
module dac_rate_fifo
  import dac_rate_fifo_pkg::*;
#(
  parameter int DATA_W     = 20,
  parameter int PAIR_DEPTH = 4,
  parameter int OSR        = 256,
  localparam int CNT_W = $clog2(PAIR_DEPTH + 1),
  localparam int LVL_W = CNT_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   mclkEnA,
  input  logic                   mclkEnB,
  input  logic [RATE_CODE_W-1:0] rateCode,
  input  logic                   wrEn,
  input  logic [DATA_W-1:0]      wrData,
  output logic                   osStb,
  output logic                   sampleStb,
  output logic                   pcmStb,
  output logic [DATA_W-1:0]      pcmLeft,
  output logic [DATA_W-1:0]      pcmRight,
  output logic [LVL_W-1:0]       fifoLevel,
  output logic                   svcReq,
  output logic                   underrunFlag,
  output logic                   overflowFlag
);

  localparam int PTR_W = (PAIR_DEPTH > 1) ? $clog2(PAIR_DEPTH) : 1;

  fifoCtl_t         ctl;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  dac_rate_gen #(.OSR(OSR)) uRate (
    .clk(clk), .rstN(rstN), .mclkEnA(mclkEnA), .mclkEnB(mclkEnB),
    .rateCode(rateCode), .osStb(osStb), .sampleStb(sampleStb)
  );

  dac_fifo_ctrl #(.PAIR_DEPTH(PAIR_DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .sampleStb(sampleStb),
    .ctl(ctl), .wrPtr(wrPtr), .rdPtr(rdPtr), .fifoLevel(fifoLevel),
    .svcReq(svcReq), .underrunFlag(underrunFlag), .overflowFlag(overflowFlag)
  );

  dac_fifo_data #(.DATA_W(DATA_W), .PAIR_DEPTH(PAIR_DEPTH)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrData(wrData), .sampleStb(sampleStb), .pcmStb(pcmStb),
    .pcmLeft(pcmLeft), .pcmRight(pcmRight)
  );

endmodule

// File: rtl/dac_rate_fifo_chk.sv
module dac_rate_fifo_chk #(
  parameter int DATA_W     = 20,
  parameter int PAIR_DEPTH = 4,
  parameter int LVL_W      = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        rateCode,
  input logic              wrEn,
  input logic              osStb,
  input logic              sampleStb,
  input logic              pcmStb,
  input logic [DATA_W-1:0] pcmLeft,
  input logic [LVL_W-1:0]  fifoLevel,
  input logic              svcReq,
  input logic              underrunFlag,
  input logic              overflowFlag
);

  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(2 * PAIR_DEPTH);
  localparam logic [LVL_W-1:0] LVL_REQ = LVL_W'(2 * PAIR_DEPTH - 3);

  assert_sample_on_os_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> osStb);

  assert_silent_bad_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rateCode) > 4'd8) |-> (!osStb && !sampleStb));

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_MAX);

  assert_out_after_sample_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> pcmStb);

  assert_hold_in_sample_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!pcmStb && !sampleStb) |=> $stable(pcmLeft));

  assert_underrun_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    underrunFlag |=> underrunFlag);

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && fifoLevel == LVL_MAX && !sampleStb) |=> (fifoLevel == LVL_MAX && overflowFlag));

  assert_req_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    svcReq == (fifoLevel <= LVL_REQ));

endmodule

bind dac_rate_fifo dac_rate_fifo_chk #(
  .DATA_W(DATA_W), .PAIR_DEPTH(PAIR_DEPTH), .LVL_W(LVL_W)
) uChk (
  .clk(clk), .rstN(rstN), .rateCode(rateCode), .wrEn(wrEn), .osStb(osStb),
  .sampleStb(sampleStb), .pcmStb(pcmStb), .pcmLeft(pcmLeft),
  .fifoLevel(fifoLevel), .svcReq(svcReq), .underrunFlag(underrunFlag),
  .overflowFlag(overflowFlag)
);

// File: tb/sim_dac_rate_fifo.sv
module sim_dac_rate_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int DW  = 20;
  localparam int OSR = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          mclkEnA = 1'b1;
  logic          mclkEnB = 1'b0;
  logic [3:0]    rateCode = 4'd15;
  logic          wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          osStb, sampleStb, pcmStb, svcReq, underrunFlag, overflowFlag;
  logic [DW-1:0] pcmLeft, pcmRight;
  logic [3:0]    fifoLevel;

  int testCnt = 0;
  int failCnt = 0;

  dac_rate_fifo #(.DATA_W(DW), .PAIR_DEPTH(4), .OSR(OSR)) u0 (
    .clk(clk), .rstN(rstN), .mclkEnA(mclkEnA), .mclkEnB(mclkEnB),
    .rateCode(rateCode), .wrEn(wrEn), .wrData(wrData), .osStb(osStb),
    .sampleStb(sampleStb), .pcmStb(pcmStb), .pcmLeft(pcmLeft),
    .pcmRight(pcmRight), .fifoLevel(fifoLevel), .svcReq(svcReq),
    .underrunFlag(underrunFlag), .overflowFlag(overflowFlag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(negedge clk) mclkEnB <= ~mclkEnB;

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++;
    $display("FAIL watchdog: run did not complete (actual timeout, expected finish)");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0;
    repeat (3) cycle();
    rstN = 1'b1;
    cycle();
  endtask

  task automatic writeWord(input logic [DW-1:0] d);
    wrEn = 1'b1; wrData = d;
    cycle();
    wrEn = 1'b0;
  endtask

  function automatic int expDiv(input int code);
    case (code)
      0, 1: return 2;
      2: return 3;
      3, 4: return 4;
      5: return 6;
      6, 7: return 8;
      default: return 12;
    endcase
  endfunction

  function automatic bit expFamB(input int code);
    return (code == 1 || code == 4 || code == 7);
  endfunction

  function automatic bit expReq(input int pairs);
    return (4 - pairs) >= 2;
  endfunction

  // Measure first latency after a code change and the steady sample period.
  task automatic measureRate(input int code);
    int n, os, per;
    per = expDiv(code) * OSR * (expFamB(code) ? 2 : 1);
    rateCode = 4'(code);
    n = 0;
    do begin cycle(); n++; end while (!sampleStb && n < 2000);
    if (!expFamB(code))
      chk(n == per + 1, "R3", "restart latency", n, per + 1);
    n = 0; os = 0;
    do begin cycle(); n++; if (osStb) os++; end while (!sampleStb && n < 2000);
    chk(n == per, "R1", $sformatf("sample period code %0d", code), n, per);
    chk(os == OSR, "R2", $sformatf("os strobes per sample code %0d", code), os, OSR);
  endtask

  // Wait for the next output pair; check hold during sampleStb and the pair.
  task automatic waitPair(input logic [DW-1:0] oldL, input logic [DW-1:0] expL,
                          input logic [DW-1:0] expR, input string req);
    int n = 0;
    while (!sampleStb && n < 2000) begin cycle(); n++; end
    chk(pcmLeft == oldL, "R5", "hold during sampleStb", pcmLeft, oldL);
    cycle();
    chk(pcmStb == 1'b1, "R5", "pcmStb one cycle after sampleStb", pcmStb, 1);
    chk(pcmLeft == expL, req, "left word", pcmLeft, expL);
    chk(pcmRight == expR, req, "right word", pcmRight, expR);
  endtask

  logic [DW-1:0] dl [4];
  logic [DW-1:0] dr [4];

  initial begin
    void'($urandom(32'd7));
    doReset();

    // R9 reset state
    chk(fifoLevel == 0, "R9", "level", fifoLevel, 0);
    chk(!underrunFlag && !overflowFlag, "R9", "flags", {underrunFlag, overflowFlag}, 0);
    chk(svcReq == 1'b1, "R9", "svcReq", svcReq, 1);
    chk(pcmLeft == 0 && pcmRight == 0 && !pcmStb, "R9", "outputs", pcmLeft, 0);
    chk(!osStb && !sampleStb, "R9", "strobes", {osStb, sampleStb}, 0);

    // R3 unused codes stay silent
    for (int k = 0; k < 3; k++) begin
      int cnt = 0;
      rateCode = 4'(9 + ($urandom % 7));
      repeat (300) begin cycle(); if (osStb || sampleStb) cnt++; end
      chk(cnt == 0, "R3", $sformatf("strobes for code %0d", rateCode), cnt, 0);
    end

    // R1/R2/R3 every valid code
    for (int c = 0; c <= 8; c++) measureRate(c);

    // Directed fill with the rate stopped
    rateCode = 4'd15;
    doReset();
    for (int p = 0; p < 4; p++) begin
      dl[p] = 20'($urandom); dr[p] = 20'($urandom);
      writeWord(dl[p]);
      chk(fifoLevel == 4'(2 * p + 1), "R4", "level after left", fifoLevel, 2 * p + 1);
      chk(svcReq == expReq(p), "R8", "svcReq after left", svcReq, expReq(p));
      writeWord(dr[p]);
      chk(fifoLevel == 4'(2 * p + 2), "R4", "level after right", fifoLevel, 2 * p + 2);
      chk(svcReq == expReq(p + 1), "R8", "svcReq after right", svcReq, expReq(p + 1));
    end
    chk(overflowFlag == 1'b0, "R7", "no overflow before full write", overflowFlag, 0);
    writeWord(20'hABCDE);
    chk(fifoLevel == 4'd8, "R7", "level after dropped write", fifoLevel, 8);
    chk(overflowFlag == 1'b1, "R7", "overflow flag", overflowFlag, 1);
    cycle();
    chk(overflowFlag == 1'b1, "R7", "overflow sticky", overflowFlag, 1);

    // Drain in order, then underrun
    rateCode = 4'd0;
    waitPair(20'h0, dl[0], dr[0], "R10");
    for (int p = 1; p < 4; p++) waitPair(dl[p-1], dl[p], dr[p], "R10");
    chk(underrunFlag == 1'b0, "R6", "no underrun while data", underrunFlag, 0);
    waitPair(dl[3], dl[3], dr[3], "R6");
    chk(underrunFlag == 1'b1, "R6", "underrun flag", underrunFlag, 1);
    // Order kept after the dropped write: next pair is exactly (A, B)
    writeWord(20'h12345);
    writeWord(20'h6789A);
    waitPair(dl[3], 20'h12345, 20'h6789A, "R7");
    chk(underrunFlag == 1'b1, "R6", "underrun sticky", underrunFlag, 1);

    // Random phase against a model, family B 44.1k
    doReset();
    begin
      int mCnt = 0, mHead = 0, mTail = 0;
      bit mSide = 0, mUnd = 0, mOvf = 0, expStb = 0;
      logic [DW-1:0] mL [4];
      logic [DW-1:0] mR [4];
      logic [DW-1:0] mPend = '0, expL = '0, expR = '0;
      rateCode = 4'd1;
      for (int i = 0; i < 4000; i++) begin
        bit w, doPush, doStage;
        logic [DW-1:0] d;
        chk(fifoLevel == 4'(2 * mCnt + int'(mSide)), "R4", "random level",
            fifoLevel, 2 * mCnt + int'(mSide));
        chk(svcReq == expReq(mCnt), "R8", "random svcReq", svcReq, expReq(mCnt));
        chk(underrunFlag == mUnd, "R6", "random underrun", underrunFlag, mUnd);
        chk(overflowFlag == mOvf, "R7", "random overflow", overflowFlag, mOvf);
        chk(pcmStb == expStb, "R5", "random pcmStb", pcmStb, expStb);
        if (pcmStb) begin
          chk(pcmLeft == expL, "R10", "random left", pcmLeft, expL);
          chk(pcmRight == expR, "R10", "random right", pcmRight, expR);
        end
        w = ($urandom % 100) < (((i / 500) % 2 == 1) ? 7 : 2);
        d = 20'($urandom);
        wrEn = w; wrData = d;
        doPush  = w && mSide;
        doStage = w && !mSide && mCnt < 4;
        if (w && !mSide && mCnt == 4) mOvf = 1;
        expStb = sampleStb;
        if (sampleStb) begin
          if (mCnt > 0) begin
            expL = mL[mHead]; expR = mR[mHead];
            mHead = (mHead + 1) % 4; mCnt--;
          end else mUnd = 1;
        end
        if (doPush) begin
          mL[mTail] = mPend; mR[mTail] = d;
          mTail = (mTail + 1) % 4; mCnt++; mSide = 0;
        end
        if (doStage) begin mPend = d; mSide = 1; end
        cycle();
      end
      wrEn = 1'b0;
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule